// File: doc/BRIEF.md
# EDO DRAM Strobe Interface Emulator

This block stands in for the device side of an extended-data-out DRAM, so that a memory controller can be verified against a target that behaves like one. A fast system clock samples the device's active-low strobes: a row strobe, a lower and an upper column strobe, a write enable and an output enable. It also samples a 9-bit multiplexed address bus and a 16-bit write data bus. Each strobe edge is found by comparing the current sample with the previous one. All timing is measured in whole sample-clock periods.

A small storage array holds the data. It is indexed by the low bits of the row and column addresses, so simulation stays cheap. The block decodes early writes, reads, read-modify-write, page-mode column cycling, refresh with the column strobe asserted first, row-only refresh and hidden refresh. Instead of a bidirectional pin, the read data bus comes out as a data vector plus one drive-enable bit per byte lane. The two column strobes act as byte lanes. The block keeps its own 9-bit refresh row counter, and the counter value is a port.

The strobe interface is asynchronous by nature, so it has no valid/ready handshake and no back-pressure. The controller alone sets the pace through its strobe edges. Every port is a plain level.

Top module: `edo_strobe_emu`

## Requirements
- R1: A falling row strobe with both column strobes high latches the row from `addr`. The first falling column strobe after that latches the column from `addr`. The storage index is {row[ROW_BITS-1:0], col[COL_BITS-1:0]}.
- R2: Lane 0 is the lower column strobe `lcas_n`, and it owns data bits 7:0 and `dq_oe[0]`. Lane 1 is the upper column strobe `ucas_n`, and it owns bits 15:8 and `dq_oe[1]`. Only the lanes whose strobe falls are read or written.
- R3: If any column strobe is low when the row strobe falls, `refresh_row` increases by one in the next cycle, wrapping from 511 to 0. In that case `addr` is ignored and storage is unchanged. At any other time `refresh_row` holds its value.
- R4: If `we_n` is low in the same sample as a falling column strobe, `dq_in` is written to that lane. `dq_oe` then stays 0 for the rest of the cycle.
- R5: If a column strobe falls with `we_n` high during a row access, the stored lane data appears on `dq_out` one clock later. The lane's `dq_oe` bit is 1 while `oe_n` is low.
- R6: A falling `we_n` while a column strobe is low after a read writes `dq_in` into the lanes whose strobe is low. `dq_out` keeps showing the data that was read before the write.
- R7: While the row strobe stays low, read data stays driven after the column strobes rise. The next falling column strobe latches a new column, and one clock later its data appears on `dq_out`.
- R8: One clock after a sample in which the row strobe and both column strobes are all high, `dq_oe` is 0. While `oe_n` is high, `dq_oe` is 0 at once.
- R9: Raising and then lowering the row strobe while a column strobe is held low after a read keeps the read data driven. This is the hidden refresh case, and it advances `refresh_row` as in R3.
- R10: During and right after reset, `dq_oe` is 0 and `refresh_row` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the controller |
| dq_out | output | 16 | Read data toward the controller |
| dq_oe | output | 2 | Per-lane drive enable for `dq_out` |
| refresh_row | output | 9 | Internal refresh row counter |

## Verification
The bench builds the block with ROW_BITS=3 and COL_BITS=3, which gives a 64-word array. It first fills every word with word writes, so every random read after that has a known expected value. The small depth makes address collisions between random writes, reads and read-modify-write cycles frequent, and that stresses byte-lane merging. The refresh counter keeps its full 9-bit width, so a run of 512 refreshes with the column strobe first brings the 511-to-0 wrap within reach.

// File: rtl/edo_emu_pkg.sv
package edo_emu_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_ACCESS  = 2'd1,
    MODE_REFRESH = 2'd2
  } edo_mode_e;
endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  output logic             ras_fall,
  output logic             first_fall,
  output logic [LANES-1:0] lane_fall,
  output logic             we_fall,
  output logic             cas_idle
);
  logic             ras_q;
  logic [LANES-1:0] cas_q;
  logic             we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= '1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  assign ras_fall   = ras_q & ~ras_n;
  assign lane_fall  = cas_q & ~cas_n;
  assign first_fall = (&cas_q) & ~(&cas_n);
  assign we_fall    = we_q & ~we_n;
  assign cas_idle   = &cas_n;
endmodule

// File: rtl/edo_refresh_counter.sv
module edo_refresh_counter #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int IW    = 6,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic [LANES-1:0] wr_lane,
  input  logic [IW-1:0]    idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data
);
  localparam int DEPTH = 1 << IW;
  localparam int LW    = DW / LANES;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_lane[l]) cells[idx][l*LW +: LW] <= wr_data[l*LW +: LW];
    end
  end

  assign rd_data = cells[idx];
endmodule

// File: rtl/edo_cycle_ctrl.sv
module edo_cycle_ctrl
  import edo_emu_pkg::*;
#(
  parameter int RB    = 4,
  parameter int CB    = 4,
  parameter int DW    = 16,
  parameter int LANES = 2,
  localparam int IW   = RB + CB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic [RB-1:0]    row_addr,
  input  logic [CB-1:0]    col_addr,
  input  logic             ras_fall,
  input  logic             first_fall,
  input  logic [LANES-1:0] lane_fall,
  input  logic             we_fall,
  input  logic             cas_idle,
  input  logic [DW-1:0]    rd_data,
  output logic [IW-1:0]    idx,
  output logic [LANES-1:0] wr_lane,
  output logic             ref_step,
  output logic [LANES-1:0] lane_drv,
  output logic [DW-1:0]    dout
);
  localparam int LW = DW / LANES;

  edo_mode_e        mode_q;
  logic [RB-1:0]    row_q;
  logic [CB-1:0]    col_q;
  logic             early_q;
  logic [CB-1:0]    col_eff;
  logic             early_eff;
  logic             access;
  logic [LANES-1:0] cas_low;
  logic [LANES-1:0] lane_hit;
  logic             rmw_hit;

  assign cas_low   = ~cas_n;
  assign access    = (mode_q == MODE_ACCESS) & ~ras_n;
  assign col_eff   = first_fall ? col_addr : col_q;
  assign early_eff = first_fall ? ~we_n : early_q;
  assign idx       = {row_q, col_eff};
  assign lane_hit  = lane_fall & {LANES{access}};
  assign rmw_hit   = we_fall & access & ~early_q & ~first_fall;
  assign ref_step  = ras_fall & ~cas_idle;

  always_comb begin
    wr_lane = '0;
    if (early_eff)    wr_lane = lane_hit;
    else if (rmw_hit) wr_lane = cas_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      row_q  <= '0;
    end else if (ras_fall) begin
      mode_q <= cas_idle ? MODE_ACCESS : MODE_REFRESH;
      if (cas_idle) row_q <= row_addr;
    end else if (ras_n) begin
      mode_q <= MODE_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      early_q <= 1'b0;
    end else if (first_fall && access) begin
      col_q   <= col_addr;
      early_q <= ~we_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_drv <= '0;
      dout     <= '0;
    end else if (cas_idle && (ras_n || mode_q == MODE_REFRESH)) begin
      lane_drv <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_hit[l]) begin
          lane_drv[l] <= ~early_eff;
          if (!early_eff) dout[l*LW +: LW] <= rd_data[l*LW +: LW];
        end else if (first_fall && access) begin
          lane_drv[l] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/edo_strobe_emu.sv
module edo_strobe_emu #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ras_n,
  input  logic        lcas_n,
  input  logic        ucas_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [8:0]  addr,
  input  logic [15:0] dq_in,
  output logic [15:0] dq_out,
  output logic [1:0]  dq_oe,
  output logic [8:0]  refresh_row
);
  localparam int LANES = 2;
  localparam int DW    = 16;
  localparam int IW    = ROW_BITS + COL_BITS;

  logic [LANES-1:0] cas_n;
  logic             ras_fall, first_fall, we_fall, cas_idle, ref_step;
  logic [LANES-1:0] lane_fall, wr_lane, lane_drv;
  logic [IW-1:0]    idx;
  logic [DW-1:0]    rd_data;

  assign cas_n = {ucas_n, lcas_n};

  edo_strobe_sampler #(.LANES(LANES)) u_smp (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ras_fall(ras_fall), .first_fall(first_fall), .lane_fall(lane_fall),
    .we_fall(we_fall), .cas_idle(cas_idle)
  );

  edo_cycle_ctrl #(.RB(ROW_BITS), .CB(COL_BITS), .DW(DW), .LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .row_addr(addr[ROW_BITS-1:0]), .col_addr(addr[COL_BITS-1:0]),
    .ras_fall(ras_fall), .first_fall(first_fall), .lane_fall(lane_fall),
    .we_fall(we_fall), .cas_idle(cas_idle), .rd_data(rd_data),
    .idx(idx), .wr_lane(wr_lane), .ref_step(ref_step),
    .lane_drv(lane_drv), .dout(dq_out)
  );

  edo_cell_array #(.IW(IW), .DW(DW), .LANES(LANES)) u_mem (
    .clk(clk), .wr_lane(wr_lane), .idx(idx), .wr_data(dq_in), .rd_data(rd_data)
  );

  edo_refresh_counter #(.CW(9)) u_ref (
    .clk(clk), .rst_n(rst_n), .step(ref_step), .row(refresh_row)
  );

  assign dq_oe = lane_drv & {LANES{~oe_n}};
endmodule

// File: rtl/edo_strobe_emu_chk.sv
module edo_strobe_emu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       lcas_n,
  input logic       ucas_n,
  input logic       we_n,
  input logic       oe_n,
  input logic [1:0] dq_oe,
  input logic [8:0] refresh_row
);
  logic ras_p, lcas_p, ucas_p;
  logic first_c, step_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b1; lcas_p <= 1'b1; ucas_p <= 1'b1;
    end else begin
      ras_p <= ras_n; lcas_p <= lcas_n; ucas_p <= ucas_n;
    end
  end

  assign first_c = lcas_p & ucas_p & ~(lcas_n & ucas_n);
  assign step_c  = ras_p & ~ras_n & ~(lcas_n & ucas_n);

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> dq_oe == 2'b00);
  p_standby_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && lcas_n && ucas_n) |=> dq_oe == 2'b00);
  p_early_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (first_c && !we_n) |=> dq_oe == 2'b00);
  p_refresh_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_c |=> refresh_row == 9'($past(refresh_row) + 9'd1));
  p_refresh_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_c |=> $stable(refresh_row));
endmodule

bind edo_strobe_emu edo_strobe_emu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
  .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .refresh_row(refresh_row)
);

// File: tb/edo_strobe_emu_tb.sv
module edo_strobe_emu_tb;
  localparam int RB = 3;
  localparam int CB = 3;
  localparam int NW = 1 << (RB + CB);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [8:0]  refresh_row;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] mdl [NW];
  logic [8:0]  cnt_m = '0;

  edo_strobe_emu #(.ROW_BITS(RB), .COL_BITS(CB)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .refresh_row(refresh_row)
  );

  always #4 clk = ~clk;

  function automatic int widx(input logic [8:0] r, input logic [8:0] c);
    return int'({r[RB-1:0], c[CB-1:0]});
  endfunction

  function automatic logic [15:0] lmask(input logic [1:0] lanes);
    return {{8{lanes[1]}}, {8{lanes[0]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic release_all();
    ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    tick();
  endtask

  task automatic set_cas(input logic [1:0] lanes);
    lcas_n = ~lanes[0];
    ucas_n = ~lanes[1];
  endtask

  task automatic do_write(input logic [8:0] r, input logic [8:0] c, input logic [15:0] d, input logic [1:0] lanes);
    ras_n = 1'b0; addr = r; tick();
    addr = c; we_n = 1'b0; dq_in = d; set_cas(lanes); tick();
    chk(dq_oe == 2'b00, "R4 early write keeps bus off", dq_oe, 0);
    tick();
    chk(dq_oe == 2'b00, "R4 early write bus off later", dq_oe, 0);
    release_all();
    mdl[widx(r, c)] = (mdl[widx(r, c)] & ~lmask(lanes)) | (d & lmask(lanes));
  endtask

  task automatic do_read(input logic [8:0] r, input logic [8:0] c, input logic [1:0] lanes);
    logic [15:0] e;
    e = mdl[widx(r, c)] & lmask(lanes);
    ras_n = 1'b0; addr = r; tick();
    addr = c; set_cas(lanes); tick();
    chk((dq_out & lmask(lanes)) == e, "R5 R1 R2 read data", dq_out & lmask(lanes), e);
    chk(dq_oe == lanes, "R2 lane drive enables", dq_oe, lanes);
    set_cas(2'b00); tick();
    chk(dq_oe == lanes && (dq_out & lmask(lanes)) == e, "R7 data held after column strobe rise", {dq_oe, dq_out}, {lanes, e});
    ras_n = 1'b1; tick();
    chk(dq_oe == 2'b00, "R8 standby turns bus off", dq_oe, 0);
  endtask

  task automatic do_page(input logic [8:0] r, input logic [8:0] c1, input logic [8:0] c2);
    ras_n = 1'b0; addr = r; tick();
    addr = c1; set_cas(2'b11); tick();
    chk(dq_out == mdl[widx(r, c1)], "R7 page first column", dq_out, mdl[widx(r, c1)]);
    set_cas(2'b00); addr = 9'h1FF; tick();
    chk(dq_out == mdl[widx(r, c1)] && dq_oe == 2'b11, "R7 page hold", dq_out, mdl[widx(r, c1)]);
    addr = c2; set_cas(2'b11); tick();
    chk(dq_out == mdl[widx(r, c2)], "R7 page second column", dq_out, mdl[widx(r, c2)]);
    release_all();
  endtask

  task automatic do_rmw(input logic [8:0] r, input logic [8:0] c, input logic [15:0] d, input logic [1:0] lanes);
    logic [15:0] old;
    old = mdl[widx(r, c)] & lmask(lanes);
    ras_n = 1'b0; addr = r; tick();
    addr = c; set_cas(lanes); tick();
    chk((dq_out & lmask(lanes)) == old, "R6 read phase", dq_out & lmask(lanes), old);
    we_n = 1'b0; dq_in = d; tick();
    chk((dq_out & lmask(lanes)) == old && dq_oe == lanes, "R6 old data kept after write", dq_out & lmask(lanes), old);
    release_all();
    mdl[widx(r, c)] = (mdl[widx(r, c)] & ~lmask(lanes)) | (d & lmask(lanes));
  endtask

  task automatic do_cbr(input logic [8:0] a);
    set_cas(2'b11); tick();
    ras_n = 1'b0; addr = a; tick();
    cnt_m = cnt_m + 9'd1;
    chk(refresh_row == cnt_m, "R3 refresh counter step", refresh_row, cnt_m);
    release_all();
  endtask

  initial begin
    logic [1:0] ln;
    logic [8:0] r, c;
    void'($urandom(32'h5EED));
    repeat (3) tick();
    chk(dq_oe == 2'b00 && refresh_row == 9'd0, "R10 reset state", {dq_oe, refresh_row}, 0);
    rst_n = 1'b1; tick();
    chk(dq_oe == 2'b00 && refresh_row == 9'd0, "R10 after reset", {dq_oe, refresh_row}, 0);

    for (int i = 0; i < NW; i++) begin
      mdl[i] = '0;
      do_write(9'(i >> CB), 9'(i % (1 << CB)), 16'($urandom), 2'b11);
    end

    // R1: upper address bits beyond the index width alias to the same word
    do_write(9'h101, 9'h0F2, 16'hA55A, 2'b11);
    do_read(9'h001, 9'h002, 2'b11);
    // R2 byte lanes
    do_write(9'd2, 9'd3, 16'h12AB, 2'b01);
    do_read(9'd2, 9'd3, 2'b01);
    do_write(9'd2, 9'd3, 16'hCD34, 2'b10);
    do_read(9'd2, 9'd3, 2'b10);
    do_read(9'd2, 9'd3, 2'b11);
    // R8 output enable gating
    ras_n = 1'b0; addr = 9'd4; tick();
    addr = 9'd5; set_cas(2'b11); tick();
    oe_n = 1'b1; #1;
    chk(dq_oe == 2'b00, "R8 oe high gates bus", dq_oe, 0);
    oe_n = 1'b0; #1;
    chk(dq_oe == 2'b11, "R8 oe low restores bus", dq_oe, 2'b11);
    // R9 hidden refresh
    ras_n = 1'b1; tick();
    chk(dq_oe == 2'b11 && dq_out == mdl[widx(9'd4, 9'd5)], "R9 data held with row strobe high", dq_out, mdl[widx(9'd4, 9'd5)]);
    ras_n = 1'b0; addr = 9'h0AA; tick();
    cnt_m = cnt_m + 9'd1;
    chk(refresh_row == cnt_m, "R9 hidden refresh counter", refresh_row, cnt_m);
    chk(dq_oe == 2'b11 && dq_out == mdl[widx(9'd4, 9'd5)], "R9 data kept during hidden refresh", dq_out, mdl[widx(9'd4, 9'd5)]);
    release_all();
    chk(dq_oe == 2'b00, "R8 off after hidden refresh", dq_oe, 0);
    // row-only refresh leaves counter
    ras_n = 1'b0; addr = 9'd6; tick(); tick();
    release_all();
    chk(refresh_row == cnt_m, "R3 row-only refresh keeps counter", refresh_row, cnt_m);
    // R3 wrap and address ignored
    for (int k = 0; k < 512; k++) do_cbr(9'($urandom));
    chk(refresh_row == cnt_m, "R3 counter after wrap", refresh_row, cnt_m);
    for (int i = 0; i < NW; i += 9) do_read(9'(i >> CB), 9'(i % (1 << CB)), 2'b11);

    for (int n = 0; n < 300; n++) begin
      r = 9'($urandom); c = 9'($urandom);
      ln = 2'($urandom_range(1, 3));
      case ($urandom % 4)
        0: do_write(r, c, 16'($urandom), ln);
        1: do_read(r, c, ln);
        2: do_rmw(r, c, 16'($urandom), ln);
        default: do_page(r, c, 9'($urandom));
      endcase
    end
    for (int i = 0; i < NW; i++) do_read(9'(i >> CB), 9'(i % (1 << CB)), 2'b11);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule